// File: doc/BRIEF.md
# Accumulator Microcontroller Core

This block is a small 8-bit microcontroller core built around one working register W. It reads 12-bit instruction words from an external 256-word program store through an 8-bit fetch address, and operates on a 5-bit file address space. That space holds three I/O ports at 0x05 (A, 4 bits), 0x06 (B, 8 bits) and 0x07 (C, 8 bits), and 24 general registers at 0x08 to 0x1F. Each port has an output latch and a direction register. A direction bit of 1 makes the pin an input. The pins, latches and directions are kept as separate signals so that the pad logic outside can build the tristate buffers.

Every instruction takes two clocks: a fetch clock and an execute clock. Operations on file registers carry a destination bit that sends the result either to W or back to the register. Bit-test instructions can suppress the next instruction. Subroutine calls save their return address on a two-entry hardware stack, and the return instruction loads a literal into W as it returns.

Top module: `acc_mcu`

## Requirements
- R1: After reset, imem_addr is 0, W is 0, every direction bit of every port is 1 (input) and every output latch is 0.
- R2: Every instruction uses two clock cycles. On the first clock of each instruction, imem_addr advances by one, so a run of no-ops shows the address sequence 0,1,1,2,2,... on successive clocks after reset. Word 0x000 is a no-op.
- R3: Literal load 0xC00|k sets W to k. Store 0x080|f copies W into file register f.
- R4: File operations are encoded 0x400|op<<7|d<<5|f, with op 0 = pass, 1 = increment, 2 = add W, 3 = and W, 4 = nibble swap. With d=0 the result goes to W and f is unchanged. With d=1 the result goes to f and W is unchanged.
- R5: Increment gives f+1, add gives W+f (both modulo 256), and gives W&f, and nibble swap gives {f[3:0], f[7:4]}.
- R6: 0x100|f clears file register f, and 0x180 clears W.
- R7: 0x800|b<<5|f skips the next instruction when bit b of f is 0. 0xA00|b<<5|f skips it when that bit is 1. A skipped instruction still takes its two clocks but changes no register, port or stack entry.
- R8: 0xE00|k jumps to address k. 0xF00|k calls address k and saves the address after the call. 0xD00|k returns to the most recently saved address and loads k into W.
- R9: The return stack holds two addresses. A third nested call discards the oldest entry. A return keeps the bottom entry, so further returns go back to that same address.
- R10: 0x200|f with f = 0x05, 0x06 or 0x07 copies W (its low 4 bits for port A) into that port's direction register. Other addresses are ignored.
- R11: Reading a port address gives the pin value on input bits and the latch value on output bits. Writing a port address changes only the latch, never the direction register.
- R12: File addresses 0x00 to 0x04 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program store address (registered) |
| imem_data | input | 12 | Instruction word at imem_addr, valid in the same cycle |
| porta_pins | input | 4 | Port A pin levels |
| porta_out | output | 4 | Port A output latch |
| porta_dir | output | 4 | Port A direction, 1 = input |
| portb_pins | input | 8 | Port B pin levels |
| portb_out | output | 8 | Port B output latch |
| portb_dir | output | 8 | Port B direction, 1 = input |
| portc_pins | input | 8 | Port C pin levels |
| portc_out | output | 8 | Port C output latch |
| portc_dir | output | 8 | Port C direction, 1 = input |

## Verification
A wrong fetch phase or program counter appears on imem_addr within one or two clocks, because the address must step once every two clocks. Corrupted W, a corrupted general register or a wrong destination choice stays hidden until a store moves the value onto a port latch. For that reason, every scenario ends by writing its results to port latches and holding in a self-loop before the latches are compared. A fault in the skip flag or the return stack changes which instructions execute. It shows up as a missing or extra port write, or as a wrong literal reaching a port, some instructions after the fault.

// File: rtl/acc_mcu_pkg.sv
package acc_mcu_pkg;
  localparam int DW  = 8;   // data width
  localparam int IW  = 12;  // instruction width
  localparam int PCW = 8;   // program address width
  localparam int FW  = 5;   // file address width

  localparam logic [FW-1:0] FA_PORTA = 5'h05;
  localparam logic [FW-1:0] FA_PORTB = 5'h06;
  localparam logic [FW-1:0] FA_PORTC = 5'h07;
  localparam logic [FW-1:0] FA_GPR0  = 5'h08;

  typedef enum logic [3:0] {
    OP_NOP, OP_STW, OP_ZF, OP_ZW, OP_DIR,
    OP_PASS, OP_INC, OP_ADD, OP_AND, OP_SWAP,
    OP_SKC, OP_SKS, OP_LDW, OP_RETL, OP_JMP, OP_JSR
  } op_e;

  typedef struct packed {
    op_e           op;
    logic          dst_f;
    logic [FW-1:0] fa;
    logic [2:0]    bsel;
    logic [DW-1:0] lit;
  } dec_t;
endpackage

// File: rtl/acc_mcu_decode.sv
module acc_mcu_decode
  import acc_mcu_pkg::*;
(
  input  logic [IW-1:0] ir,
  output dec_t          d
);
  always_comb begin
    d.fa    = ir[FW-1:0];
    d.dst_f = ir[5];
    d.bsel  = ir[7:5];
    d.lit   = ir[7:0];
    d.op    = OP_NOP;
    unique case (ir[11:10])
      2'b11: begin
        unique case (ir[9:8])
          2'b00: d.op = OP_LDW;
          2'b01: d.op = OP_RETL;
          2'b10: d.op = OP_JMP;
          default: d.op = OP_JSR;
        endcase
      end
      2'b10: d.op = ir[9] ? OP_SKS : OP_SKC;
      2'b01: begin
        case (ir[9:7])
          3'd0: d.op = OP_PASS;
          3'd1: d.op = OP_INC;
          3'd2: d.op = OP_ADD;
          3'd3: d.op = OP_AND;
          3'd4: d.op = OP_SWAP;
          default: d.op = OP_NOP;
        endcase
      end
      default: begin
        case (ir[9:7])
          3'd1: d.op = OP_STW;
          3'd2: d.op = OP_ZF;
          3'd3: d.op = OP_ZW;
          3'd4: d.op = OP_DIR;
          default: d.op = OP_NOP;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/acc_mcu_gpr.sv
module acc_mcu_gpr #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/acc_mcu_pio.sv
module acc_mcu_pio #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_lat,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lat,
  output logic [W-1:0] dir,
  output logic [W-1:0] rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= '0;
      dir <= '1;
    end else begin
      if (wr_lat) lat <= wdata;
      if (wr_dir) dir <= wdata;
    end
  end

  assign rd = (dir & pins) | (~dir & lat);

  assert_dir_reset_R1: assert property (@(posedge clk) rst |=> (dir == '1 && lat == '0));
  assert_latch_only_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_lat && !wr_dir) |=> $stable(dir));
endmodule

// File: rtl/acc_mcu_stack.sv
module acc_mcu_stack #(
  parameter int DEPTH = 2,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_val,
  input  logic          pop,
  output logic [AW-1:0] top
);
  logic [AW-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push) begin
      ent[0] <= push_val;
      for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
    end
  end

  assign top = ent[0];

  assert_push_top_R9: assert property (@(posedge clk) disable iff (rst)
    push |=> (top == $past(push_val)));
endmodule

// File: rtl/acc_mcu.sv
module acc_mcu
  import acc_mcu_pkg::*;
#(
  parameter int PA_W  = 4,
  parameter int PB_W  = 8,
  parameter int PC_W  = 8,
  parameter int STK_D = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PCW-1:0]   imem_addr,
  input  logic [IW-1:0]    imem_data,
  input  logic [PA_W-1:0]  porta_pins,
  output logic [PA_W-1:0]  porta_out,
  output logic [PA_W-1:0]  porta_dir,
  input  logic [PB_W-1:0]  portb_pins,
  output logic [PB_W-1:0]  portb_out,
  output logic [PB_W-1:0]  portb_dir,
  input  logic [PC_W-1:0]  portc_pins,
  output logic [PC_W-1:0]  portc_out,
  output logic [PC_W-1:0]  portc_dir
);
  logic           phase;   // 0 = fetch, 1 = execute
  logic [PCW-1:0] pc;
  logic [IW-1:0]  ir;
  logic           skip_q;
  logic [DW-1:0]  w;
  dec_t           d;

  logic [DW-1:0]  rf_rdata, fval, res;
  logic [PA_W-1:0] pa_rd;
  logic [PB_W-1:0] pb_rd;
  logic [PC_W-1:0] pc_rd;
  logic           exec_en, is_fop, to_f, f_wr, skip_set, tbit;
  logic           rf_we, pa_we, pb_we, pc_we, pa_dw, pb_dw, pc_dw;
  logic           push, pop;
  logic [PCW-1:0] stk_top;

  acc_mcu_decode u_dec (.ir(ir), .d(d));

  acc_mcu_gpr #(.AW(FW), .DW(DW)) u_gpr (
    .clk(clk), .we(rf_we), .waddr(d.fa), .wdata(res),
    .re(!phase), .raddr(imem_data[FW-1:0]), .rdata(rf_rdata)
  );

  acc_mcu_pio #(.W(PA_W)) u_pa (
    .clk(clk), .rst(rst), .wr_lat(pa_we), .wr_dir(pa_dw),
    .wdata(pa_dw ? w[PA_W-1:0] : res[PA_W-1:0]),
    .pins(porta_pins), .lat(porta_out), .dir(porta_dir), .rd(pa_rd)
  );
  acc_mcu_pio #(.W(PB_W)) u_pb (
    .clk(clk), .rst(rst), .wr_lat(pb_we), .wr_dir(pb_dw),
    .wdata(pb_dw ? w[PB_W-1:0] : res[PB_W-1:0]),
    .pins(portb_pins), .lat(portb_out), .dir(portb_dir), .rd(pb_rd)
  );
  acc_mcu_pio #(.W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .wr_lat(pc_we), .wr_dir(pc_dw),
    .wdata(pc_dw ? w[PC_W-1:0] : res[PC_W-1:0]),
    .pins(portc_pins), .lat(portc_out), .dir(portc_dir), .rd(pc_rd)
  );

  acc_mcu_stack #(.DEPTH(STK_D), .AW(PCW)) u_stk (
    .clk(clk), .rst(rst), .push(push), .push_val(pc),
    .pop(pop), .top(stk_top)
  );

  // file read mux
  always_comb begin
    if (d.fa == FA_PORTA)      fval = DW'(pa_rd);
    else if (d.fa == FA_PORTB) fval = DW'(pb_rd);
    else if (d.fa == FA_PORTC) fval = DW'(pc_rd);
    else if (d.fa >= FA_GPR0)  fval = rf_rdata;
    else                       fval = '0;
  end

  // result path
  always_comb begin
    case (d.op)
      OP_PASS: res = fval;
      OP_INC:  res = fval + 8'd1;
      OP_ADD:  res = w + fval;
      OP_AND:  res = w & fval;
      OP_SWAP: res = {fval[3:0], fval[7:4]};
      OP_STW:  res = w;
      default: res = '0;
    endcase
  end

  assign exec_en  = phase && !skip_q;
  assign is_fop   = (d.op == OP_PASS) || (d.op == OP_INC) || (d.op == OP_ADD) ||
                    (d.op == OP_AND) || (d.op == OP_SWAP);
  assign to_f     = (is_fop && d.dst_f) || (d.op == OP_STW) || (d.op == OP_ZF);
  assign f_wr     = exec_en && to_f;
  assign rf_we    = f_wr && (d.fa >= FA_GPR0);
  assign pa_we    = f_wr && (d.fa == FA_PORTA);
  assign pb_we    = f_wr && (d.fa == FA_PORTB);
  assign pc_we    = f_wr && (d.fa == FA_PORTC);
  assign pa_dw    = exec_en && (d.op == OP_DIR) && (d.fa == FA_PORTA);
  assign pb_dw    = exec_en && (d.op == OP_DIR) && (d.fa == FA_PORTB);
  assign pc_dw    = exec_en && (d.op == OP_DIR) && (d.fa == FA_PORTC);
  assign tbit     = fval[d.bsel];
  assign skip_set = exec_en && (((d.op == OP_SKC) && !tbit) || ((d.op == OP_SKS) && tbit));
  assign push     = exec_en && (d.op == OP_JSR);
  assign pop      = exec_en && (d.op == OP_RETL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      pc     <= '0;
      ir     <= '0;
      skip_q <= 1'b0;
      w      <= '0;
    end else if (!phase) begin
      ir    <= imem_data;
      pc    <= pc + 1'b1;
      phase <= 1'b1;
    end else begin
      phase  <= 1'b0;
      skip_q <= skip_set;
      if (exec_en) begin
        case (d.op)
          OP_LDW:  w <= d.lit;
          OP_RETL: begin w <= d.lit; pc <= stk_top; end
          OP_ZW:   w <= '0;
          OP_JMP, OP_JSR: pc <= d.lit;
          default: if (is_fop && !d.dst_f) w <= res;
        endcase
      end
    end
  end

  assign imem_addr = pc;

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !phase |=> (imem_addr == $past(imem_addr) + 8'd1));
  assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (phase && skip_q) |-> !(rf_we || pa_we || pb_we || pc_we || pa_dw || pb_dw || pc_dw || push || pop));
  assert_retl_w_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && d.op == OP_RETL) |=> (w == $past(d.lit)));
  assert_one_port_wr_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({pa_we, pb_we, pc_we, rf_we}) <= 1);
endmodule

// File: tb/tb_acc_mcu.sv
module tb_acc_mcu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [11:0] imem_data;
  logic [3:0]  porta_pins = 4'h0, porta_out, porta_dir;
  logic [7:0]  portb_pins = 8'h00, portb_out, portb_dir;
  logic [7:0]  portc_pins = 8'h00, portc_out, portc_dir;
  logic [11:0] prog [256];
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  assign imem_data = prog[imem_addr];

  acc_mcu dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .porta_pins(porta_pins), .porta_out(porta_out), .porta_dir(porta_dir),
    .portb_pins(portb_pins), .portb_out(portb_out), .portb_dir(portb_dir),
    .portc_pins(portc_pins), .portc_out(portc_out), .portc_dir(portc_dir)
  );

  function automatic logic [11:0] ldw(input logic [7:0] k);  return 12'hC00 | k; endfunction
  function automatic logic [11:0] retl(input logic [7:0] k); return 12'hD00 | k; endfunction
  function automatic logic [11:0] jmp(input logic [7:0] k);  return 12'hE00 | k; endfunction
  function automatic logic [11:0] jsr(input logic [7:0] k);  return 12'hF00 | k; endfunction
  function automatic logic [11:0] stw(input logic [4:0] f);  return 12'h080 | f; endfunction
  function automatic logic [11:0] zf(input logic [4:0] f);   return 12'h100 | f; endfunction
  function automatic logic [11:0] zw();                      return 12'h180; endfunction
  function automatic logic [11:0] dirw(input logic [4:0] f); return 12'h200 | f; endfunction
  function automatic logic [11:0] fop(input int op, input int dd, input logic [4:0] f);
    return 12'h400 | 12'(op << 7) | 12'(dd << 5) | 12'(f);
  endfunction
  function automatic logic [11:0] skc(input int b, input logic [4:0] f);
    return 12'h800 | 12'(b << 5) | 12'(f);
  endfunction
  function automatic logic [11:0] sks(input int b, input logic [4:0] f);
    return 12'hA00 | 12'(b << 5) | 12'(f);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 12'h000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    do_reset();
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R1 reset state, R2 two-cycle fetch cadence
  task automatic t_reset_cadence();
    clear_prog();
    do_reset();
    check("R1 addr", imem_addr, 8'h00);
    check("R1 dirA", {4'h0, porta_dir}, 8'h0F);
    check("R1 dirB", portb_dir, 8'hFF);
    check("R1 dirC", portc_dir, 8'hFF);
    check("R1 latB", portb_out, 8'h00);
    check("R1 latA", {4'h0, porta_out}, 8'h00);
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk);
      check("R2 cadence", imem_addr, 8'((k + 1) / 2));
    end
  endtask

  // R3 literal/store, R10 direction load
  task automatic t_move();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = ldw(8'hA5);
    prog[3] = stw(5'h06); prog[4] = jmp(8'd4);
    run(30);
    check("R3 store", portb_out, 8'hA5);
    check("R10 dirB", portb_dir, 8'h00);
  endtask

  // R4 destination, R5 inc/add
  task automatic t_dest();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = dirw(5'h07);
    prog[3] = ldw(8'h3C); prog[4] = stw(5'h08);
    prog[5] = fop(1, 1, 5'h08);  // R8 = 3D, W keeps 3C
    prog[6] = fop(2, 0, 5'h08);  // W = 79
    prog[7] = stw(5'h06);
    prog[8] = fop(0, 0, 5'h08);  // W = 3D
    prog[9] = stw(5'h07); prog[10] = jmp(8'd10);
    run(50);
    check("R4 R5 add to W", portb_out, 8'h79);
    check("R4 inc to f", portc_out, 8'h3D);
  endtask

  // R5 and/swap, R6 clears
  task automatic t_logic();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h05); prog[2] = dirw(5'h06); prog[3] = dirw(5'h07);
    prog[4] = ldw(8'hF3); prog[5] = stw(5'h09); prog[6] = ldw(8'h5A);
    prog[7] = fop(3, 1, 5'h09);  // R9 = 52
    prog[8] = fop(4, 0, 5'h09);  // W = 25
    prog[9] = stw(5'h06);
    prog[10] = zf(5'h09); prog[11] = fop(1, 0, 5'h09);  // W = 1
    prog[12] = stw(5'h05);
    prog[13] = ldw(8'h77); prog[14] = stw(5'h07); prog[15] = zw(); prog[16] = stw(5'h07);
    prog[17] = jmp(8'd17);
    run(80);
    check("R5 and/swap", portb_out, 8'h25);
    check("R6 clear f", {4'h0, porta_out}, 8'h01);
    check("R6 clear W", portc_out, 8'h00);
  endtask

  // R7 skips
  task automatic t_skip();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = dirw(5'h07);
    prog[3] = ldw(8'h04); prog[4] = stw(5'h0A);
    prog[5] = skc(2, 5'h0A); prog[6] = ldw(8'h11);
    prog[7] = skc(3, 5'h0A); prog[8] = ldw(8'h22);
    prog[9] = stw(5'h06);
    prog[10] = sks(2, 5'h0A); prog[11] = ldw(8'h33);
    prog[12] = sks(0, 5'h0A); prog[13] = ldw(8'h44);
    prog[14] = stw(5'h07); prog[15] = jmp(8'd15);
    run(70);
    check("R7 skip-if-clear", portb_out, 8'h11);
    check("R7 skip-if-set", portc_out, 8'h44);
  endtask

  // R8 call/return
  task automatic t_call();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = dirw(5'h07);
    prog[3] = jsr(8'd20); prog[4] = stw(5'h06);
    prog[5] = jsr(8'd30); prog[6] = stw(5'h07); prog[7] = jmp(8'd7);
    prog[20] = retl(8'h5E);
    prog[30] = jsr(8'd40); prog[31] = retl(8'h66);
    prog[40] = retl(8'h01);
    run(60);
    check("R8 return literal", portb_out, 8'h5E);
    check("R8 nested return", portc_out, 8'h66);
  endtask

  // R9 stack depth
  task automatic t_stack();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = dirw(5'h07);
    prog[3] = jsr(8'd10); prog[4] = stw(5'h07); prog[5] = jmp(8'd5);
    prog[10] = jsr(8'd20); prog[11] = stw(5'h06); prog[12] = retl(8'h99);
    prog[20] = jsr(8'd30); prog[21] = retl(8'h21);
    prog[30] = retl(8'h30);
    run(80);
    check("R9 bottom kept", portb_out, 8'h99);
    check("R9 oldest dropped", portc_out, 8'h00);
  endtask

  // R11 port read mix, R10 partial direction
  task automatic t_ports();
    clear_prog();
    porta_pins = 4'hA; portb_pins = 8'hF3;
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h07); prog[2] = ldw(8'h0F); prog[3] = dirw(5'h06);
    prog[4] = ldw(8'h50); prog[5] = stw(5'h06);
    prog[6] = fop(0, 0, 5'h06);  // W = 53
    prog[7] = fop(2, 0, 5'h05);  // W = 5D
    prog[8] = stw(5'h07); prog[9] = stw(5'h05); prog[10] = jmp(8'd10);
    run(50);
    check("R11 read mix", portc_out, 8'h5D);
    check("R11 latch B", portb_out, 8'h50);
    check("R10 dirB", portb_dir, 8'h0F);
    check("R11 latch A", {4'h0, porta_out}, 8'h0D);
    check("R11 dirA kept", {4'h0, porta_dir}, 8'h0F);
    porta_pins = 4'h0; portb_pins = 8'h00;
  endtask

  // R12 reserved addresses
  task automatic t_reserved();
    clear_prog();
    prog[0] = ldw(8'h00); prog[1] = dirw(5'h06); prog[2] = ldw(8'h77); prog[3] = stw(5'h03);
    prog[4] = ldw(8'h12); prog[5] = fop(2, 0, 5'h03); prog[6] = stw(5'h06); prog[7] = jmp(8'd7);
    run(40);
    check("R12 reserved reads 0", portb_out, 8'h12);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset_cadence();
    t_move();
    t_dest();
    t_logic();
    t_skip();
    t_call();
    t_stack();
    t_ports();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule